// File: doc/BRIEF.md
# Message Timestamp Timer with Drift Correction

This block is the 16-bit free-running time base that a message controller uses to stamp traffic. The counter advances by one on each enabled clock tick. A programmable correction period periodically replaces one normal step with a correction step, which either holds the count or adds two. Software can write the counter, the reload offset, the correction period and a small control register. A capture register latches the counter on a capture event while capture is armed.

The block also reacts when a receive mailbox with its compare-match flag set stores a message. Depending on two control bits, it reloads the counter from the offset register, disarms capture, or does both, so that the captured value is frozen. The match event raises no interrupt here; receive signalling belongs to other logic.

The correction scheduler is a three-state machine. `CORR_OFF` is the state while the period is zero. `CORR_RUN` counts normal ticks. `CORR_DUE` marks that the next tick is a correction step. The scheduler moves on these transitions:
- A restart (counter reload, counter write or period write) enters `CORR_OFF` when the period is 0, `CORR_DUE` when it is 1, and `CORR_RUN` otherwise.
- A tick in `CORR_RUN` moves to `CORR_DUE` once P-1 normal ticks have elapsed.
- A tick in `CORR_DUE` applies the correction and returns to `CORR_RUN`, or stays in `CORR_DUE` when P is 1.

The capture unit has two states:
- `CAP_ARMED` moves to `CAP_FROZEN` on a match freeze or on a software write of 0.
- `CAP_FROZEN` moves to `CAP_ARMED` on a software write of 1 with no freeze in the same cycle.

Top module: `msg_stamp_timer`

## Requirements
- R1: After reset the counter, capture register and all control bits (ctrl_q) read 0, and correction is off.
- R2: When mbx_store and mbx_match are both 1 and ctrl bit 0 (reload-on-match) is 1, the counter takes the offset register value at the next edge. This takes priority over a counter write or a tick in the same cycle. With mbx_match 0 or bit 0 clear, the counter is left unchanged.
- R3: When mbx_store and mbx_match are both 1 and ctrl bit 1 (freeze-on-match) is 1, capture becomes disarmed (cap_en and ctrl_q bit 3 read 0) and cap_q keeps its value. This happens even if a capture event or a software re-arm falls in the same cycle.
- R4: Outside correction steps, the counter adds 1 on each cycle with tick_en high, wrapping modulo 2^16. Without tick_en it holds.
- R5: With period P>0, every P-th tick since the last restart is a correction step. With ctrl bit 2 (direction) at 0 the counter holds for that tick; with bit 2 at 1 it adds 2 (modulo 2^16).
- R6: A period value of 0 disables correction, so every tick adds 1.
- R7: A counter reload, a counter write or a period write restarts the correction count. A tick in the same cycle as a load is absorbed by the load. A tick in the same cycle as a period write is a normal +1 step.
- R8: While capture is armed, cap_evt copies the counter value present in that cycle (before that edge's update) into cap_q. While disarmed, cap_q holds. Writing ctrl bit 3 sets or clears the arm bit.
- R9: ctrl_q reports reload-on-match, freeze-on-match, direction and arm in bits 0 to 3. Bits 7:4 are reserved and always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter clock-enable tick |
| mbx_store | input | 1 | A receive mailbox stored a message this cycle |
| mbx_match | input | 1 | Compare-match flag of that mailbox |
| cap_evt | input | 1 | Capture event |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_wdata | input | 16 | Offset write data |
| per_we | input | 1 | Correction-period write strobe |
| per_wdata | input | 16 | Correction-period write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| cnt_q | output | 16 | Timer counter value |
| cap_q | output | 16 | Capture register |
| cap_en | output | 1 | Capture armed |
| ctrl_q | output | 8 | Control register read value |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a match-triggered reload and a software counter write (or a tick): the bench raises mbx_store, mbx_match and cnt_we together and expects the offset, not the written value. The second pair is a match freeze and a capture event (or a software re-arm): the bench drives them on the same edge and expects cap_q unchanged and the arm bit low. A correction step that falls due on the same tick as a counter or period write is also provoked, and the count after the following ticks shows whether the phase was restarted.

// File: rtl/tst_pkg.sv
package tst_pkg;

    typedef enum logic [1:0] {
        CORR_OFF = 2'd0,
        CORR_RUN = 2'd1,
        CORR_DUE = 2'd2
    } corr_state_e;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_TWO  = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        SRC_KEEP   = 2'd0,
        SRC_RELOAD = 2'd1,
        SRC_SW     = 2'd2,
        SRC_STEP   = 2'd3
    } cnt_src_e;

    typedef enum logic {
        CAP_FROZEN = 1'b0,
        CAP_ARMED  = 1'b1
    } cap_state_e;

    localparam int CB_RELOAD = 0;
    localparam int CB_FREEZE = 1;
    localparam int CB_DIR    = 2;
    localparam int CB_ARM    = 3;
    localparam int CB_USED   = 4;

endpackage

// File: rtl/tst_corr_fsm.sv
module tst_corr_fsm
    import tst_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_wdata,
    input  logic             dir_up,
    output step_e            step
);

    localparam int EXT_W = PER_W + 1;

    corr_state_e      state, state_d;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] phase, phase_d;
    logic [PER_W-1:0] per_next;
    logic             restart;
    logic             run_done;

    assign per_next = per_we ? per_wdata : per_q;
    assign restart  = load | per_we;
    assign run_done = ({1'b0, phase} + EXT_W'(1)) == ({1'b0, per_q} - EXT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (per_we) begin
            per_q <= per_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CORR_OFF;
            phase <= '0;
        end else begin
            state <= state_d;
            phase <= phase_d;
        end
    end

    always_comb begin
        state_d = state;
        phase_d = phase;
        if (restart) begin
            phase_d = '0;
            if (per_next == '0) begin
                state_d = CORR_OFF;
            end else if (per_next == PER_W'(1)) begin
                state_d = CORR_DUE;
            end else begin
                state_d = CORR_RUN;
            end
        end else if (tick) begin
            unique case (state)
                CORR_OFF: begin
                    state_d = CORR_OFF;
                end
                CORR_RUN: begin
                    if (run_done) begin
                        state_d = CORR_DUE;
                        phase_d = '0;
                    end else begin
                        phase_d = phase + PER_W'(1);
                    end
                end
                CORR_DUE: begin
                    phase_d = '0;
                    state_d = (per_q == PER_W'(1)) ? CORR_DUE : CORR_RUN;
                end
                default: begin
                    state_d = CORR_OFF;
                    phase_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        if (!tick) begin
            step = STEP_IDLE;
        end else if (state == CORR_DUE && !per_we) begin
            step = dir_up ? STEP_TWO : STEP_HOLD;
        end else begin
            step = STEP_ONE;
        end
    end

    // R6: a zero period never yields a correction step
    p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0) |-> (step == STEP_IDLE || step == STEP_ONE));

    // R5: after a correction tick the phase starts again from zero
    p_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == CORR_DUE && !restart) |=> (phase == '0));

    // R7: every restart clears the phase
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));

endmodule

// File: rtl/tst_counter.sv
module tst_counter
    import tst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_ev,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             sw_we,
    input  logic [CNT_W-1:0] sw_val,
    input  step_e            step,
    output logic [CNT_W-1:0] cnt_q
);

    cnt_src_e         src;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] inc;

    always_comb begin
        if (reload_ev) begin
            src = SRC_RELOAD;
        end else if (sw_we) begin
            src = SRC_SW;
        end else if (step != STEP_IDLE) begin
            src = SRC_STEP;
        end else begin
            src = SRC_KEEP;
        end
    end

    always_comb begin
        unique case (step)
            STEP_ONE: inc = CNT_W'(1);
            STEP_TWO: inc = CNT_W'(2);
            default:  inc = '0;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_KEEP:   cnt_d = cnt_q;
            SRC_RELOAD: cnt_d = reload_val;
            SRC_SW:     cnt_d = sw_val;
            SRC_STEP:   cnt_d = cnt_q + inc;
            default:    cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2: a match reload always lands the offset
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_ev |=> (cnt_q == $past(reload_val)));

    // R5: a hold correction leaves the count untouched
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_ev && !sw_we && step == STEP_HOLD) |=> $stable(cnt_q));

    // R5: an advancing correction adds two
    p_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_ev && !sw_we && step == STEP_TWO) |=> (cnt_q == $past(cnt_q) + CNT_W'(2)));

    // R4: no tick and no load keeps the count
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_ev && !sw_we && step == STEP_IDLE) |=> $stable(cnt_q));

endmodule

// File: rtl/tst_capture.sv
module tst_capture
    import tst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_ev,
    input  logic             sw_we,
    input  logic             sw_arm,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cap_q,
    output logic             armed
);

    cap_state_e state, state_d;
    logic       take;

    always_comb begin
        state_d = state;
        unique case (state)
            CAP_ARMED: begin
                if (freeze_ev || (sw_we && !sw_arm)) begin
                    state_d = CAP_FROZEN;
                end
            end
            CAP_FROZEN: begin
                if (!freeze_ev && sw_we && sw_arm) begin
                    state_d = CAP_ARMED;
                end
            end
            default: state_d = CAP_FROZEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_FROZEN;
        end else begin
            state <= state_d;
        end
    end

    assign armed = (state == CAP_ARMED);
    assign take  = armed && cap_evt && !freeze_ev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (take) begin
            cap_q <= cnt_in;
        end
    end

    // R3: a match freeze disarms and keeps the captured value
    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_ev |=> (!armed && $stable(cap_q)));

    // R8: an armed capture takes the counter value of that cycle
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cap_evt && !freeze_ev) |=> (cap_q == $past(cnt_in)));

    // R8: while disarmed the capture register holds
    p_noarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(cap_q));

endmodule

// File: rtl/msg_stamp_timer.sv
module msg_stamp_timer
    import tst_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PER_W  = 16,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              mbx_store,
    input  logic              mbx_match,
    input  logic              cap_evt,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              ofs_we,
    input  logic [CNT_W-1:0]  ofs_wdata,
    input  logic              per_we,
    input  logic [PER_W-1:0]  per_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cap_q,
    output logic              cap_en,
    output logic [CTRL_W-1:0] ctrl_q
);

    localparam int RSV_W = CTRL_W - CB_USED;

    logic [CB_ARM-1:0] mode_q;
    logic [CNT_W-1:0]  ofs_q;
    logic              match_ev;
    logic              reload_ev;
    logic              freeze_ev;
    step_e             step;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ofs_q  <= '0;
        end else begin
            if (ctrl_we) begin
                mode_q <= ctrl_wdata[CB_ARM-1:0];
            end
            if (ofs_we) begin
                ofs_q <= ofs_wdata;
            end
        end
    end

    assign match_ev  = mbx_store & mbx_match;
    assign reload_ev = match_ev & mode_q[CB_RELOAD];
    assign freeze_ev = match_ev & mode_q[CB_FREEZE];

    tst_corr_fsm #(.PER_W(PER_W)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .load      (reload_ev | cnt_we),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .dir_up    (mode_q[CB_DIR]),
        .step      (step)
    );

    tst_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_ev  (reload_ev),
        .reload_val (ofs_q),
        .sw_we      (cnt_we),
        .sw_val     (cnt_wdata),
        .step       (step),
        .cnt_q      (cnt_q)
    );

    tst_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_ev (freeze_ev),
        .sw_we     (ctrl_we),
        .sw_arm    (ctrl_wdata[CB_ARM]),
        .cap_evt   (cap_evt),
        .cnt_in    (cnt_q),
        .cap_q     (cap_q),
        .armed     (cap_en)
    );

    assign ctrl_q = {{RSV_W{1'b0}}, cap_en, mode_q};

    // R2: without the reload bit a match never touches a software-written count
    p_noreload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev && !mode_q[CB_RELOAD] && cnt_we) |=> (cnt_q == $past(cnt_wdata)));

    // R9: a control write lands the mode bits
    p_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_q[CB_ARM-1:0] == $past(ctrl_wdata[CB_ARM-1:0])));

endmodule

// File: tb/tb_msg_stamp_timer.sv
`timescale 1ns/1ps
module tb_msg_stamp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        mbx_store = 1'b0;
    logic        mbx_match = 1'b0;
    logic        cap_evt = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        ofs_we = 1'b0;
    logic [15:0] ofs_wdata = '0;
    logic        per_we = 1'b0;
    logic [15:0] per_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [15:0] cnt_q;
    logic [15:0] cap_q;
    logic        cap_en;
    logic [7:0]  ctrl_q;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    msg_stamp_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .mbx_store(mbx_store), .mbx_match(mbx_match), .cap_evt(cap_evt),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ofs_we(ofs_we), .ofs_wdata(ofs_wdata),
        .per_we(per_we), .per_wdata(per_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt_q(cnt_q), .cap_q(cap_q), .cap_en(cap_en), .ctrl_q(ctrl_q)
    );

    // period, direction, start value, tick count, expected count
    localparam int NVEC = 7;
    localparam logic [56:0] VEC [NVEC] = '{
        {16'd0,     1'b0, 16'd100,    8'd10, 16'd110},
        {16'd3,     1'b0, 16'd100,    8'd10, 16'd107},
        {16'd3,     1'b1, 16'd100,    8'd10, 16'd113},
        {16'd1,     1'b0, 16'd100,    8'd5,  16'd100},
        {16'd1,     1'b1, 16'd100,    8'd5,  16'd110},
        {16'd4,     1'b1, 16'hFFFE,   8'd4,  16'h0003},
        {16'd2,     1'b0, 16'hFFFF,   8'd3,  16'h0001}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_per(input logic [15:0] v);
        per_we = 1'b1; per_wdata = v;
        @(negedge clk);
        per_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wr_ofs(input logic [15:0] v);
        ofs_we = 1'b1; ofs_wdata = v;
        @(negedge clk);
        ofs_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic store(input logic match);
        mbx_store = 1'b1; mbx_match = match;
        @(negedge clk);
        mbx_store = 1'b0; mbx_match = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cnt", cnt_q, 16'h0);
        chk("R1 cap", cap_q, 16'h0);
        chk("R1 ctrl", {8'h0, ctrl_q}, 16'h0);
        ticks(3);
        chk("R1 no correction after reset", cnt_q, 16'd3);

        // R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr_per(VEC[i][56:41]);
            wr_ctrl({5'b0, VEC[i][40], 2'b00});
            wr_cnt(VEC[i][39:24]);
            ticks(int'(VEC[i][23:16]));
            chk($sformatf("R4/R5/R6 vector %0d", i), cnt_q, VEC[i][15:0]);
        end

        // R4 hold without tick
        repeat (5) @(negedge clk);
        chk("R4 idle hold", cnt_q, 16'h0001);

        // R7 counter write restarts the phase, tick absorbed
        wr_per(16'd3);
        wr_ctrl(8'h04);
        wr_cnt(16'd0);
        ticks(2);
        chk("R7 setup", cnt_q, 16'd2);
        cnt_we = 1'b1; cnt_wdata = 16'd10; tick_en = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0; tick_en = 1'b0;
        chk("R7 write beats tick", cnt_q, 16'd10);
        ticks(2);
        chk("R7 phase restarted by write", cnt_q, 16'd12);
        ticks(1);
        chk("R7 correction after restart", cnt_q, 16'd14);

        // R7 period write with tick gives a normal step
        wr_cnt(16'd0);
        ticks(2);
        per_we = 1'b1; per_wdata = 16'd3; tick_en = 1'b1;
        @(negedge clk);
        per_we = 1'b0; tick_en = 1'b0;
        chk("R7 period write tick normal", cnt_q, 16'd3);
        ticks(2);
        chk("R7 phase restarted by period", cnt_q, 16'd5);
        ticks(1);
        chk("R7 correction due", cnt_q, 16'd7);

        // R2 reload on match
        wr_per(16'd0);
        wr_ctrl(8'h01);
        wr_ofs(16'h1234);
        wr_cnt(16'd5);
        store(1'b0);
        chk("R2 no match flag", cnt_q, 16'd5);
        store(1'b1);
        chk("R2 reload", cnt_q, 16'h1234);
        wr_cnt(16'd5);
        mbx_store = 1'b1; mbx_match = 1'b1; cnt_we = 1'b1; cnt_wdata = 16'h9999; tick_en = 1'b1;
        @(negedge clk);
        mbx_store = 1'b0; mbx_match = 1'b0; cnt_we = 1'b0; tick_en = 1'b0;
        chk("R2 reload beats write and tick", cnt_q, 16'h1234);
        wr_ctrl(8'h00);
        wr_cnt(16'd7);
        store(1'b1);
        chk("R2 reload bit clear", cnt_q, 16'd7);

        // R8 capture
        wr_ctrl(8'h08);
        chk("R8 armed", {15'b0, cap_en}, 16'd1);
        wr_cnt(16'h0042);
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R8 capture", cap_q, 16'h0042);
        wr_cnt(16'h0050);
        cap_evt = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0; tick_en = 1'b0;
        chk("R8 capture pre-update value", cap_q, 16'h0050);
        chk("R8 counter advanced", cnt_q, 16'h0051);
        wr_ctrl(8'h00);
        cap_evt = 1'b1;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R8 disarmed hold", cap_q, 16'h0050);

        // R3 freeze on match
        wr_ctrl(8'h0A);
        mbx_store = 1'b1; mbx_match = 1'b1; cap_evt = 1'b1;
        @(negedge clk);
        mbx_store = 1'b0; mbx_match = 1'b0; cap_evt = 1'b0;
        chk("R3 cap kept", cap_q, 16'h0050);
        chk("R3 disarmed", {15'b0, cap_en}, 16'd0);
        chk("R3 ctrl arm bit", {15'b0, ctrl_q[3]}, 16'd0);
        chk("R3 counter untouched", cnt_q, 16'h0051);
        mbx_store = 1'b1; mbx_match = 1'b1; ctrl_we = 1'b1; ctrl_wdata = 8'h0A;
        @(negedge clk);
        mbx_store = 1'b0; mbx_match = 1'b0; ctrl_we = 1'b0;
        chk("R3 freeze beats rearm", {15'b0, cap_en}, 16'd0);
        wr_ctrl(8'h0A);
        chk("R3 rearm", {15'b0, cap_en}, 16'd1);
        store(1'b0);
        chk("R3 no match keeps arm", {15'b0, cap_en}, 16'd1);

        // R9 reserved bits
        wr_ctrl(8'hFF);
        chk("R9 reserved read zero", {8'h0, ctrl_q}, 16'h000F);
        wr_ctrl(8'h05);
        chk("R9 layout", {8'h0, ctrl_q}, 16'h0005);

        finish_run();
    end

endmodule